// File: doc/BRIEF.md
# Store Buffer with Read-Miss Bypass

This block sits between a write-through cache and the next level of memory. Each store the processor issues goes into a small first-in first-out queue and the processor moves on at once. The queue sends its stores to memory one at a time through a single request port with a valid/ready handshake. A full queue raises a stall to the processor. Two stores to the same address stay as two separate entries, so memory sees every store in program order.

Read misses get priority over queued stores. When a read is accepted, its address is compared in parallel with every queued entry, including a store accepted in the same cycle. If any entry matches, the youngest match supplies the data, no memory read is made, and the answer comes back on the next cycle. If nothing matches, the read goes to memory ahead of every queued store, and draining stops until the read data returns. The processor never sees a value that an earlier store has already replaced.

Top module: `wt_store_buf`

## Requirements
- R1: While reset is held and right after it, the queue is empty: `wr_stall`=0, `mem_req_valid`=0, `rd_ready`=1, `rd_resp_valid`=0.
- R2: A store is taken on a clock edge where `wr_valid`=1 and `wr_stall`=0. `wr_stall` is 1 exactly when DEPTH entries are held. A store offered while `wr_stall`=1 is never stored and never reaches memory.
- R3: While no read miss is in progress, the oldest entry is shown on the memory port with `mem_req_we`=1 (1 = write, 0 = read). It is removed on the edge where `mem_req_ready`=1. One entry leaves per handshake, in the order the entries were taken.
- R4: Stores to an address already queued are not merged. Each one reaches memory as its own write, in order, so memory ends up holding the last value.
- R5: A read request is taken when `rd_valid`=1 and `rd_ready`=1. `rd_ready` is 0 from acceptance until the read has been answered. Each accepted read gets exactly one single-cycle `rd_resp_valid` pulse.
- R6: If the read address matches a queued entry, `rd_resp_data` carries the data of the youngest matching entry. `rd_resp_valid` rises in the cycle after acceptance, and no memory read is issued.
- R7: A store taken in the same cycle as a read counts as older than that read, so a matching address forwards that store's data.
- R8: A read that matches nothing is shown on the memory port with `mem_req_we`=0 from the cycle after acceptance, ahead of all queued stores. Its response is given in the cycle after `mem_resp_valid`, carrying `mem_resp_data`.
- R9: No queued store is handed to memory from the acceptance of a missing read until its memory data has been captured.
- R10: Stores taken while a read miss is in progress do not change the value returned for that read. Later reads see them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Processor offers a store |
| wr_addr | input | AW | Store address |
| wr_data | input | DW | Store data |
| wr_stall | output | 1 | Queue full; store not taken |
| rd_valid | input | 1 | Processor read-miss request |
| rd_addr | input | AW | Read address |
| rd_ready | output | 1 | Read request can be taken |
| rd_resp_valid | output | 1 | Read answer valid (one cycle) |
| rd_resp_data | output | DW | Read answer data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Memory request address |
| mem_req_wdata | output | DW | Memory write data |
| mem_req_ready | input | 1 | Memory takes the request this edge |
| mem_resp_valid | input | 1 | Memory read data valid |
| mem_resp_data | input | DW | Memory read data |

## Verification
A queue pointer or count that has slipped shows up at the memory port on the next handshake: the write address or data no longer matches the order of stores the bench recorded, or the stall rises at the wrong number of entries. A faulty match or youngest-entry selection shows up on the forwarded answer one cycle after the read is taken, as a stale or older value, or as a memory read that should not have happened. A read controller that drains stores too early shows as a write handshake while a read is outstanding. A read whose value was overwritten shows in the response a few cycles later.

// File: rtl/wsb_pkg.sv
package wsb_pkg;

  typedef enum logic [1:0] {
    RD_IDLE,
    RD_ISSUE,
    RD_WAIT,
    RD_REPLY
  } rd_state_e;

  // physical slot holding the entry 'age' places behind the head
  function automatic int unsigned ring_slot(int unsigned head, int unsigned age,
                                            int unsigned depth);
    int unsigned s;
    s = head + age;
    if (s >= depth) s = s - depth;
    return s;
  endfunction

  function automatic int unsigned ring_next(int unsigned p, int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/wsb_fifo.sv
module wsb_fifo
  import wsb_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [AW-1:0]                push_addr,
  input  logic [DW-1:0]                push_data,
  input  logic                         pop,
  output logic [CW-1:0]                cnt,
  output logic                         full,
  output logic                         empty,
  output logic [AW-1:0]                head_addr,
  output logic [DW-1:0]                head_data,
  output logic [DEPTH-1:0][AW-1:0]     age_addr,
  output logic [DEPTH-1:0][DW-1:0]     age_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) tail_q <= PW'(ring_next(32'(tail_q), DEPTH));
      if (pop)  head_q <= PW'(ring_next(32'(head_q), DEPTH));
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[tail_q] <= push_addr;
      data_q[tail_q] <= push_data;
    end
  end

  // entries presented oldest first
  for (genvar k = 0; k < DEPTH; k++) begin : g_age
    assign age_addr[k] = addr_q[PW'(ring_slot(32'(head_q), k, DEPTH))];
    assign age_data[k] = data_q[PW'(ring_slot(32'(head_q), k, DEPTH))];
  end

  assign cnt       = cnt_q;
  assign full      = (cnt_q == CW'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign head_addr = addr_q[head_q];
  assign head_data = data_q[head_q];

endmodule

// File: rtl/wsb_fwd.sv
module wsb_fwd #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0]             cnt,
  input  logic [DEPTH-1:0][AW-1:0]  age_addr,
  input  logic [DEPTH-1:0][DW-1:0]  age_data,
  input  logic [AW-1:0]             look_addr,
  input  logic                      new_valid,
  input  logic [AW-1:0]             new_addr,
  input  logic [DW-1:0]             new_data,
  output logic                      hit,
  output logic [DW-1:0]             hit_data
);
  logic [DEPTH-1:0] match;
  logic             new_match;

  for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
    assign match[k] = (cnt > CW'(k)) && (age_addr[k] == look_addr);
  end

  assign new_match = new_valid && (new_addr == look_addr);

  // later (younger) matches override older ones; a same-cycle store is youngest
  always_comb begin
    hit      = (|match) || new_match;
    hit_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (match[k]) hit_data = age_data[k];
    end
    if (new_match) hit_data = new_data;
  end

endmodule

// File: rtl/wsb_rdctl.sv
module wsb_rdctl
  import wsb_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  input  logic          fwd_hit,
  input  logic [DW-1:0] fwd_data,
  input  logic          mem_ready,
  input  logic          mem_resp_valid,
  input  logic [DW-1:0] mem_resp_data,
  output logic          rd_ready,
  output logic          rd_fire,
  output logic          resp_valid,
  output logic [DW-1:0] resp_data,
  output logic          issue,
  output logic [AW-1:0] issue_addr,
  output logic          wait_mem,
  output logic          drain_ok
);
  rd_state_e     state_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  assign rd_ready = (state_q == RD_IDLE);
  assign rd_fire  = rd_valid && rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      unique case (state_q)
        RD_IDLE: if (rd_fire) begin
          addr_q <= rd_addr;
          if (fwd_hit) begin
            data_q  <= fwd_data;
            state_q <= RD_REPLY;
          end else begin
            state_q <= RD_ISSUE;
          end
        end
        RD_ISSUE: if (mem_ready) state_q <= RD_WAIT;
        RD_WAIT: if (mem_resp_valid) begin
          data_q  <= mem_resp_data;
          state_q <= RD_REPLY;
        end
        RD_REPLY: state_q <= RD_IDLE;
        default:  state_q <= RD_IDLE;
      endcase
    end
  end

  assign issue      = (state_q == RD_ISSUE);
  assign issue_addr = addr_q;
  assign wait_mem   = (state_q == RD_ISSUE) || (state_q == RD_WAIT);
  assign drain_ok   = !wait_mem;
  assign resp_valid = (state_q == RD_REPLY);
  assign resp_data  = data_q;

endmodule

// File: rtl/wt_store_buf.sv
module wt_store_buf #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          wr_stall,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_ready,
  output logic          rd_resp_valid,
  output logic [DW-1:0] rd_resp_data,
  output logic          mem_req_valid,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_req_ready,
  input  logic          mem_resp_valid,
  input  logic [DW-1:0] mem_resp_data
);
  localparam int CW = $clog2(DEPTH + 1);

  logic                    push, pop;
  logic [CW-1:0]           fifo_cnt;
  logic                    fifo_full, fifo_empty;
  logic [AW-1:0]           head_addr;
  logic [DW-1:0]           head_data;
  logic [DEPTH-1:0][AW-1:0] age_addr;
  logic [DEPTH-1:0][DW-1:0] age_data;
  logic                    fwd_hit;
  logic [DW-1:0]           fwd_data;
  logic                    rd_fire, rd_issue, wait_mem, drain_ok;
  logic [AW-1:0]           rd_issue_addr;
  logic                    drain_req;

  assign wr_stall = fifo_full;
  assign push     = wr_valid && !fifo_full;

  wsb_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .CW(CW)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_addr (wr_addr),
    .push_data (wr_data),
    .pop       (pop),
    .cnt       (fifo_cnt),
    .full      (fifo_full),
    .empty     (fifo_empty),
    .head_addr (head_addr),
    .head_data (head_data),
    .age_addr  (age_addr),
    .age_data  (age_data)
  );

  wsb_fwd #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .CW(CW)) u_fwd (
    .cnt       (fifo_cnt),
    .age_addr  (age_addr),
    .age_data  (age_data),
    .look_addr (rd_addr),
    .new_valid (push),
    .new_addr  (wr_addr),
    .new_data  (wr_data),
    .hit       (fwd_hit),
    .hit_data  (fwd_data)
  );

  wsb_rdctl #(.AW(AW), .DW(DW)) u_rdctl (
    .clk            (clk),
    .rst_n          (rst_n),
    .rd_valid       (rd_valid),
    .rd_addr        (rd_addr),
    .fwd_hit        (fwd_hit),
    .fwd_data       (fwd_data),
    .mem_ready      (mem_req_ready),
    .mem_resp_valid (mem_resp_valid),
    .mem_resp_data  (mem_resp_data),
    .rd_ready       (rd_ready),
    .rd_fire        (rd_fire),
    .resp_valid     (rd_resp_valid),
    .resp_data      (rd_resp_data),
    .issue          (rd_issue),
    .issue_addr     (rd_issue_addr),
    .wait_mem       (wait_mem),
    .drain_ok       (drain_ok)
  );

  // memory port: a waiting read miss wins over queued stores
  assign drain_req     = drain_ok && !fifo_empty;
  assign pop           = drain_req && mem_req_ready;
  assign mem_req_valid = rd_issue || drain_req;
  assign mem_req_we    = !rd_issue;
  assign mem_req_addr  = rd_issue ? rd_issue_addr : head_addr;
  assign mem_req_wdata = rd_issue ? '0 : head_data;

endmodule

// File: rtl/wsb_chk.sv
module wsb_chk #(
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_stall,
  input logic [CW-1:0] cnt,
  input logic          push,
  input logic          pop,
  input logic          rd_fire,
  input logic          fwd_hit,
  input logic          rd_resp_valid,
  input logic          wait_mem
);
  p_stall_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(DEPTH)) |-> wr_stall);

  p_no_push_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stall |-> !push);

  p_count_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == $past(cnt) + CW'($past(push)) - CW'($past(pop)));

  p_hit_reply_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && fwd_hit) |=> rd_resp_valid);

  p_single_reply_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_resp_valid |=> !rd_resp_valid);

  p_hold_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wait_mem |-> !pop);

endmodule

bind wt_store_buf wsb_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_stall      (wr_stall),
  .cnt           (fifo_cnt),
  .push          (push),
  .pop           (pop),
  .rd_fire       (rd_fire),
  .fwd_hit       (fwd_hit),
  .rd_resp_valid (rd_resp_valid),
  .wait_mem      (wait_mem)
);

// File: tb/sim_wt_store_buf.sv
`timescale 1ns/1ps
module sim_wt_store_buf;
  localparam int AW = 16, DW = 32, DEPTH = 4, LAT = 2;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, rd_valid = 0, mem_req_ready = 0;
  logic [AW-1:0] wr_addr = 0, rd_addr = 0;
  logic [DW-1:0] wr_data = 0;
  logic wr_stall, rd_ready, rd_resp_valid, mem_req_valid, mem_req_we;
  logic [DW-1:0] rd_resp_data, mem_req_wdata;
  logic [AW-1:0] mem_req_addr;
  logic mem_resp_valid = 0;
  logic [DW-1:0] mem_resp_data = 0;

  always #10 clk = ~clk;

  wt_store_buf #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u0 (.*);

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] mem_model [256];
  logic [DW-1:0] ref_mem [256];
  logic [7:0]    exp_a [256];
  logic [DW-1:0] exp_d [256];
  int exp_head = 0, exp_tail = 0;
  int n_mem_rd = 0, rsp_cnt = 0, ready_mode = 0, cyc = 0;
  logic [DW-1:0] rsp_data;
  bit rd_out = 0;

  task automatic check(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory ready pattern
  always @(negedge clk) begin
    cyc++;
    mem_req_ready <= (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? cyc[0] : 1'b0;
  end

  // memory model with order checking of drained stores
  always @(posedge clk) begin
    mem_resp_valid <= 1'b0;
    if (mem_resp_valid) rd_out = 0;
    if (rsp_cnt == 1) begin
      mem_resp_valid <= 1'b1;
      mem_resp_data  <= rsp_data;
    end
    if (rsp_cnt > 0) rsp_cnt--;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        check(!rd_out, "R9 write drained during read miss", 1, 0);
        check(exp_head < exp_tail && mem_req_addr[7:0] == exp_a[exp_head] &&
              mem_req_wdata == exp_d[exp_head], "R3/R4 drain order",
              {mem_req_addr, mem_req_wdata[15:0]},
              {8'h0, exp_a[exp_head], exp_d[exp_head][15:0]});
        mem_model[mem_req_addr[7:0]] = mem_req_wdata;
        exp_head++;
      end else begin
        rsp_cnt  = LAT;
        rsp_data = mem_model[mem_req_addr[7:0]];
        n_mem_rd++;
        rd_out = 1;
      end
    end
  end

  // all tasks start and end just after a falling edge
  task automatic do_write(logic [7:0] a, logic [DW-1:0] d);
    wr_valid = 1; wr_addr = {8'h0, a}; wr_data = d;
    while (wr_stall) @(negedge clk);
    ref_mem[a] = d;
    exp_a[exp_tail] = a; exp_d[exp_tail] = d; exp_tail++;
    @(negedge clk);
    wr_valid = 0;
  endtask

  // kind: 0 any, 1 must forward, 2 must miss
  task automatic do_read(logic [7:0] a, int kind, string tag);
    logic [DW-1:0] exp;
    int nrd0, t;
    while (!rd_ready) @(negedge clk);
    rd_valid = 1; rd_addr = {8'h0, a};
    exp = ref_mem[a];
    nrd0 = n_mem_rd;
    @(negedge clk);
    rd_valid = 0;
    check(!rd_ready, "R5 rd_ready low after accept", rd_ready, 0);
    if (kind == 1)
      check(rd_resp_valid && n_mem_rd == nrd0, {tag, " R6 next-cycle forward"},
            {rd_resp_valid, 31'(n_mem_rd - nrd0)}, {1'b1, 31'd0});
    t = 0;
    while (!rd_resp_valid && t < 300) begin @(negedge clk); t++; end
    check(rd_resp_valid, {tag, " R5 response"}, rd_resp_valid, 1);
    check(rd_resp_data == exp, tag, rd_resp_data, exp);
    if (kind == 2) check(n_mem_rd == nrd0 + 1, {tag, " R8 one memory read"}, n_mem_rd - nrd0, 1);
    @(negedge clk);
    check(!rd_resp_valid, "R5 single pulse", rd_resp_valid, 0);
  endtask

  task automatic t_reset;
    check(wr_stall == 0 && mem_req_valid == 0 && rd_ready == 1 && rd_resp_valid == 0,
          "R1 reset state", {wr_stall, mem_req_valid, rd_ready, rd_resp_valid}, 4'b0010);
  endtask

  task automatic t_fill;
    ready_mode = 2;
    @(negedge clk);
    do_write(8'd5, 32'hA1A1_0001);
    do_write(8'd5, 32'hA2A2_0002);
    do_write(8'd6, 32'hB0B0_0006);
    check(!wr_stall, "R2 no stall below depth", wr_stall, 0);
    do_write(8'd7, 32'hC0C0_0007);
    check(wr_stall, "R2 stall at depth", wr_stall, 1);
    wr_valid = 1; wr_addr = 16'd8; wr_data = 32'hDEAD_0008;
    repeat (3) @(negedge clk);
    wr_valid = 0;
    check(wr_stall, "R2 stall holds", wr_stall, 1);
    check(mem_req_valid && mem_req_we && mem_req_addr == 16'd5 && mem_req_wdata == 32'hA1A1_0001,
          "R3 oldest entry presented", mem_req_wdata, 32'hA1A1_0001);
  endtask

  task automatic t_forward;
    do_read(8'd5, 1, "R6 youngest of two matches");
    do_read(8'd7, 1, "R6 forward newest slot");
  endtask

  task automatic t_priority;
    fork
      do_read(8'd9, 2, "R8 miss reads memory");
      begin
        @(negedge clk);
        check(mem_req_valid && !mem_req_we && mem_req_addr == 16'd9,
              "R8 read ahead of queued stores", {mem_req_we, mem_req_addr}, {1'b0, 16'd9});
        ready_mode = 0;
      end
    join
    repeat (10) @(negedge clk);
    check(!wr_stall && !mem_req_valid, "R3 queue drained", mem_req_valid, 0);
    do_read(8'd5, 2, "R4 memory holds last store");
  endtask

  task automatic t_same_cycle;
    logic [DW-1:0] d = 32'h5A5A_0020;
    wr_valid = 1; wr_addr = 16'd20; wr_data = d;
    rd_valid = 1; rd_addr = 16'd20;
    ref_mem[20] = d; exp_a[exp_tail] = 8'd20; exp_d[exp_tail] = d; exp_tail++;
    @(negedge clk);
    wr_valid = 0; rd_valid = 0;
    check(rd_resp_valid && rd_resp_data == d, "R7 same-cycle store forwarded", rd_resp_data, d);
    @(negedge clk);
  endtask

  task automatic t_late_write;
    ready_mode = 2;
    repeat (2) @(negedge clk);
    fork
      do_read(8'd30, 2, "R10 outstanding read keeps old value");
      begin
        repeat (2) @(negedge clk);
        do_write(8'd30, 32'h3030_FFFF);
        ready_mode = 0;
      end
    join
    repeat (8) @(negedge clk);
    do_read(8'd30, 0, "R10 later read sees store");
  endtask

  task automatic t_mixed;
    logic [7:0] lf = 8'h5A;
    ready_mode = 1;
    for (int i = 0; i < 60; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      if (lf[0]) do_write({5'd0, lf[3:1]}, {16'hBEE0, 8'(i), lf});
      else       do_read({5'd0, lf[3:1]}, 0, "R5 mixed read");
    end
    ready_mode = 0;
    repeat (20) @(negedge clk);
    check(exp_head == exp_tail, "R3 every store written once", exp_head, exp_tail);
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem_model[i] = 32'h1000_0000 + i;
      ref_mem[i]   = 32'h1000_0000 + i;
    end
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_fill;
    t_forward;
    t_priority;
    t_same_cycle;
    t_late_write;
    t_mixed;
    report;
  end

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    report;
  end

endmodule